// File: doc/BRIEF.md
# Adaptive Decision Feedback Equalizer with Sign-Data LMS Training

This block sits after the ADC of a serial receiver. It takes one signed sample per clock. The correction for inter-symbol interference (ISI) is a weighted sum of the symbols it has already decided: every past decision is scaled by its own tap weight. The block subtracts that correction from the incoming sample. It then slices the corrected value into a two-level (NRZ) or four-level (PAM4) symbol and returns the symbol as a 2-bit code, one cycle after the sample.

The tap weights train themselves all the time, during ordinary traffic, so the equalizer follows slow changes in the channel. The slicer error is the corrected sample minus the ideal level of the chosen symbol. Each tap moves by that error times the decision k symbols back. The step size is a power of two, set by a 4-bit shift input, so the rate costs no multiplier. A freeze input stops training while equalization goes on. The tap values can be read on a flat output bus.

Taps hold TAP_W-bit signed values that carry FRAC_W fraction bits relative to the sample LSB. The unit amplitude UNIT is given in sample LSBs, and its default is 128. The design has no state machine: its only state is the decision history, the tap registers and the output register.

Top module: `lms_dfe`

## Requirements
- R1: Each sample presented with `smp_valid`=1 produces `dec_valid`=1 and a new `dec_sym` on the following clock. A cycle with `smp_valid`=0 gives `dec_valid`=0 on the next cycle, and it leaves `dec_sym`, the taps and the decision history unchanged.
- R2: The equalized value is y = x − floor(Σ h_k·d(n−k) / 2^FRAC_W), summed over k = 1..TAP_N. Here h_k is tap k and d(n−k) is the symbol level decided k samples earlier. A level is one of −3, −1, +1 or +3, or 0 for an empty history slot.
- R3: In PAM4 mode (`pam4_mode`=1) the thresholds are −2U, 0 and +2U, where U = UNIT. The slicer picks level +3 for y ≥ 2U, +1 for 0 ≤ y < 2U, −1 for −2U ≤ y < 0 and −3 below that. The Gray codes are −3→00, −1→01, +1→11, +3→10.
- R4: In NRZ mode (`pam4_mode`=0) the slicer picks level +1, coded 01, for y ≥ 0, and level −1, coded 00, otherwise. Bit 1 of `dec_sym` is always 0 in this mode.
- R5: The slicer error is e = y − L·U, where L is the level just decided.
- R6: On each valid sample that is not frozen, every tap becomes h_k + floor(e·d(n−k)·2^FRAC_W / 2^mu), where mu = `mu_shift` (0 to 15). The d(n−k) used is the history before the current decision is pushed in.
- R7: A tap update that would leave the signed TAP_W-bit range saturates at the most positive or most negative value instead of wrapping.
- R8: While `freeze`=1, valid samples are still equalized and sliced and the history still advances, but every tap keeps its value.
- R9: A synchronous reset sets all taps to 0, all history levels to 0, `dec_valid` to 0 and `dec_sym` to 00.
- R10: Tap k (k = 1..TAP_N) is read on `taps_flat[(k−1)·TAP_W +: TAP_W]` as a two's-complement value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample on `smp_data` is valid this cycle |
| smp_data | input | SMP_W | Signed ADC sample |
| pam4_mode | input | 1 | 1 = four-level slicing, 0 = two-level |
| mu_shift | input | SHIFT_W | Step-size right shift applied to each tap update |
| freeze | input | 1 | Hold all tap weights |
| dec_valid | output | 1 | `dec_sym` holds a new decision |
| dec_sym | output | 2 | Decided symbol code |
| taps_flat | output | TAP_N·TAP_W | Current tap weights, tap 1 in the low bits |

## Verification
A fault in the history register or in a tap register reaches the tap readback one cycle after the next valid sample, because each update multiplies the error by the stored levels. A faulty tap also moves the decision for any later sample that lies near a threshold. The bench therefore checks both readback and decisions. It uses samples placed so that the corrected value is exactly the uncorrected one moved across a threshold. It also drives the floor rounding of negative updates under large shifts, which exposes any off-by-one in shift direction or in which history slot pairs with which tap.

// File: rtl/lms_dfe_pkg.sv
package lms_dfe_pkg;

    // Symbol level: -3, -1, +1, +3, or 0 for an empty history slot
    typedef logic signed [2:0] lvl_t;

    localparam lvl_t LVL_N3 = 3'sb101;
    localparam lvl_t LVL_N1 = 3'sb111;
    localparam lvl_t LVL_P1 = 3'sb001;
    localparam lvl_t LVL_P3 = 3'sb011;
    localparam lvl_t LVL_Z  = 3'sb000;

    // Output code: Gray order in PAM4, {0, bit} in NRZ
    function automatic logic [1:0] lvl_code(input lvl_t lvl, input logic pam4);
        logic [1:0] code;
        if (pam4) begin
            if (lvl == LVL_P3)      code = 2'b10;
            else if (lvl == LVL_P1) code = 2'b11;
            else if (lvl == LVL_N1) code = 2'b01;
            else                    code = 2'b00;
        end else begin
            code = (lvl == LVL_P1) ? 2'b01 : 2'b00;
        end
        return code;
    endfunction

endpackage

// File: rtl/lms_dfe_slicer.sv
module lms_dfe_slicer
    import lms_dfe_pkg::*;
#(
    parameter int EQ_W = 22,
    parameter int UNIT = 128
) (
    input  logic signed [EQ_W-1:0] eq_i,
    input  logic                   pam4_i,
    output lvl_t                   lvl_o,
    output logic signed [EQ_W-1:0] err_o
);
    localparam logic signed [EQ_W-1:0] U1 = EQ_W'(UNIT);
    localparam logic signed [EQ_W-1:0] U2 = EQ_W'(2 * UNIT);
    localparam logic signed [EQ_W-1:0] U3 = EQ_W'(3 * UNIT);

    logic signed [EQ_W-1:0] ideal;

    // Threshold decision; a tie goes to the upper level
    always_comb begin
        if (pam4_i) begin
            if (eq_i >= U2)          lvl_o = LVL_P3;
            else if (!eq_i[EQ_W-1])  lvl_o = LVL_P1;
            else if (eq_i >= -U2)    lvl_o = LVL_N1;
            else                     lvl_o = LVL_N3;
        end else begin
            lvl_o = eq_i[EQ_W-1] ? LVL_N1 : LVL_P1;
        end
    end

    // Ideal amplitude of the chosen level and the residual error
    always_comb begin
        case (lvl_o)
            LVL_P3:  ideal = U3;
            LVL_P1:  ideal = U1;
            LVL_N1:  ideal = -U1;
            default: ideal = -U3;
        endcase
        err_o = eq_i - ideal;
    end

endmodule

// File: rtl/lms_dfe_isi.sv
module lms_dfe_isi
    import lms_dfe_pkg::*;
#(
    parameter int TAP_N  = 4,
    parameter int TAP_W  = 18,
    parameter int FRAC_W = 6,
    parameter int EQ_W   = 22
) (
    input  logic signed [TAP_W-1:0] taps_i [TAP_N],
    input  lvl_t                    hist_i [TAP_N],
    output logic signed [EQ_W-1:0]  isi_o
);
    localparam int PROD_W = TAP_W + 2;
    localparam int SUM_W  = PROD_W + $clog2(TAP_N) + 1;

    logic signed [PROD_W-1:0] prod [TAP_N];
    logic signed [SUM_W-1:0]  acc;

    // Level times weight by shift and add; a level magnitude is 0, 1 or 3
    for (genvar k = 0; k < TAP_N; k++) begin : g_prod
        logic signed [PROD_W-1:0] h_ext;
        logic signed [PROD_W-1:0] h_x3;
        assign h_ext = PROD_W'(taps_i[k]);
        assign h_x3  = h_ext + (h_ext <<< 1);
        always_comb begin
            case (hist_i[k])
                LVL_P3:  prod[k] = h_x3;
                LVL_P1:  prod[k] = h_ext;
                LVL_N1:  prod[k] = -h_ext;
                LVL_N3:  prod[k] = -h_x3;
                default: prod[k] = '0;
            endcase
        end
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < TAP_N; k++) begin
            acc = acc + SUM_W'(prod[k]);
        end
        isi_o = EQ_W'(acc >>> FRAC_W);
    end

endmodule

// File: rtl/lms_dfe_tap.sv
module lms_dfe_tap
    import lms_dfe_pkg::*;
#(
    parameter int TAP_W   = 18,
    parameter int FRAC_W  = 6,
    parameter int EQ_W    = 22,
    parameter int SHIFT_W = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    upd_i,
    input  logic signed [EQ_W-1:0]  err_i,
    input  lvl_t                    dat_i,
    input  logic [SHIFT_W-1:0]      mu_i,
    output logic signed [TAP_W-1:0] tap_o
);
    localparam int GR_W = EQ_W + 2;
    localparam int SC_W = GR_W + FRAC_W;
    localparam logic signed [SC_W:0] T_MAX = {{(SC_W-TAP_W+2){1'b0}}, {(TAP_W-1){1'b1}}};
    localparam logic signed [SC_W:0] T_MIN = {{(SC_W-TAP_W+2){1'b1}}, {(TAP_W-1){1'b0}}};

    logic signed [GR_W-1:0] e_ext;
    logic signed [GR_W-1:0] grad;
    logic signed [SC_W-1:0] delta;
    logic signed [SC_W:0]   raw;
    logic signed [TAP_W-1:0] nxt;

    assign e_ext = GR_W'(err_i);

    // Error times past level, no multiplier
    always_comb begin
        case (dat_i)
            LVL_P3:  grad = e_ext + (e_ext <<< 1);
            LVL_P1:  grad = e_ext;
            LVL_N1:  grad = -e_ext;
            LVL_N3:  grad = -(e_ext + (e_ext <<< 1));
            default: grad = '0;
        endcase
    end

    // Step size as an arithmetic right shift, then clamp
    always_comb begin
        delta = (SC_W'(grad) <<< FRAC_W) >>> mu_i;
        raw   = (SC_W+1)'(tap_o) + (SC_W+1)'(delta);
        if (raw > T_MAX)      nxt = TAP_W'(T_MAX);
        else if (raw < T_MIN) nxt = TAP_W'(T_MIN);
        else                  nxt = TAP_W'(raw);
    end

    always_ff @(posedge clk) begin
        if (rst)        tap_o <= '0;
        else if (upd_i) tap_o <= nxt;
    end

    AST_TAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !upd_i |=> $stable(tap_o)); // R8

    AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
        (upd_i && grad > 0) |=> tap_o >= $past(tap_o)); // R7

    AST_NO_WRAP_DN: assert property (@(posedge clk) disable iff (rst)
        (upd_i && grad < 0) |=> tap_o <= $past(tap_o)); // R7

endmodule

// File: rtl/lms_dfe.sv
module lms_dfe
    import lms_dfe_pkg::*;
#(
    parameter int SMP_W   = 12,
    parameter int TAP_N   = 4,
    parameter int TAP_W   = 18,
    parameter int FRAC_W  = 6,
    parameter int UNIT    = 128,
    parameter int SHIFT_W = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     smp_valid,
    input  logic signed [SMP_W-1:0]  smp_data,
    input  logic                     pam4_mode,
    input  logic [SHIFT_W-1:0]       mu_shift,
    input  logic                     freeze,
    output logic                     dec_valid,
    output logic [1:0]               dec_sym,
    output logic [TAP_N*TAP_W-1:0]   taps_flat
);
    localparam int EQ_W = ((TAP_W > SMP_W) ? TAP_W : SMP_W) + 4;
    localparam logic signed [EQ_W-1:0] U1 = EQ_W'(UNIT);
    localparam logic signed [EQ_W-1:0] U4 = EQ_W'(4 * UNIT);

    lvl_t                    hist_q [TAP_N];
    logic signed [TAP_W-1:0] taps   [TAP_N];
    logic signed [EQ_W-1:0]  isi_w;
    logic signed [EQ_W-1:0]  eq_w;
    logic signed [EQ_W-1:0]  err_w;
    lvl_t                    lvl_w;
    logic                    upd_w;

    lms_dfe_isi #(
        .TAP_N (TAP_N),
        .TAP_W (TAP_W),
        .FRAC_W(FRAC_W),
        .EQ_W  (EQ_W)
    ) u_isi (
        .taps_i(taps),
        .hist_i(hist_q),
        .isi_o (isi_w)
    );

    assign eq_w = EQ_W'(smp_data) - isi_w;

    lms_dfe_slicer #(
        .EQ_W(EQ_W),
        .UNIT(UNIT)
    ) u_slicer (
        .eq_i  (eq_w),
        .pam4_i(pam4_mode),
        .lvl_o (lvl_w),
        .err_o (err_w)
    );

    assign upd_w = smp_valid && !freeze;

    for (genvar k = 0; k < TAP_N; k++) begin : g_tap
        lms_dfe_tap #(
            .TAP_W  (TAP_W),
            .FRAC_W (FRAC_W),
            .EQ_W   (EQ_W),
            .SHIFT_W(SHIFT_W)
        ) u_tap (
            .clk  (clk),
            .rst  (rst),
            .upd_i(upd_w),
            .err_i(err_w),
            .dat_i(hist_q[k]),
            .mu_i (mu_shift),
            .tap_o(taps[k])
        );
        assign taps_flat[k*TAP_W +: TAP_W] = taps[k];
    end

    // Decision history: slot 0 holds the most recent decision
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < TAP_N; k++) hist_q[k] <= LVL_Z;
        end else if (smp_valid) begin
            hist_q[0] <= lvl_w;
            for (int k = 1; k < TAP_N; k++) hist_q[k] <= hist_q[k-1];
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid <= 1'b0;
            dec_sym   <= 2'b00;
        end else begin
            dec_valid <= smp_valid;
            if (smp_valid) dec_sym <= lvl_code(lvl_w, pam4_mode);
        end
    end

    AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> dec_valid); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> (!dec_valid && $stable(dec_sym))); // R1

    AST_NRZ_CODE: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !pam4_mode) |=> !dec_sym[1]); // R4

    AST_NRZ_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !pam4_mode) |-> (lvl_w == LVL_P1 || lvl_w == LVL_N1)); // R4

    AST_ERR_RANGE: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && pam4_mode && eq_w < U4 && eq_w > -U4)
            |-> (err_w <= U1 && err_w >= -U1)); // R5

endmodule

// File: tb/lms_dfe_tb.sv
module lms_dfe_tb;
    localparam int SMP_W   = 12;
    localparam int TAP_N   = 4;
    localparam int TAP_W   = 18;
    localparam int SHIFT_W = 4;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   smp_valid = 1'b0;
    logic signed [SMP_W-1:0] smp_data = '0;
    logic                   pam4_mode = 1'b0;
    logic [SHIFT_W-1:0]     mu_shift = '0;
    logic                   freeze = 1'b0;
    logic                   dec_valid;
    logic [1:0]             dec_sym;
    logic [TAP_N*TAP_W-1:0] taps_flat;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lms_dfe u_dut (
        .clk      (clk),
        .rst      (rst),
        .smp_valid(smp_valid),
        .smp_data (smp_data),
        .pam4_mode(pam4_mode),
        .mu_shift (mu_shift),
        .freeze   (freeze),
        .dec_valid(dec_valid),
        .dec_sym  (dec_sym),
        .taps_flat(taps_flat)
    );

    // {pam4, sample, expected code}, taps at zero
    localparam bit [14:0] VEC [12] = '{
        {1'b1, 12'h800, 2'b00},  // -2048 -> -3
        {1'b1, 12'hEFF, 2'b00},  // -257  -> -3
        {1'b1, 12'hF00, 2'b01},  // -256  -> -1 (tie)
        {1'b1, 12'hFFF, 2'b01},  // -1    -> -1
        {1'b1, 12'h000, 2'b11},  // 0     -> +1
        {1'b1, 12'h0FF, 2'b11},  // 255   -> +1
        {1'b1, 12'h100, 2'b10},  // 256   -> +3 (tie)
        {1'b1, 12'h7FF, 2'b10},  // 2047  -> +3
        {1'b0, 12'hFFF, 2'b00},  // NRZ -1
        {1'b0, 12'h000, 2'b01},  // NRZ 0
        {1'b0, 12'h1F4, 2'b01},  // NRZ 500
        {1'b0, 12'hE0C, 2'b00}   // NRZ -500
    };

    function automatic int tap(input int k);
        return int'($signed(taps_flat[(k-1)*TAP_W +: TAP_W]));
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int x, input logic v);
        smp_data  = SMP_W'(x);
        smp_valid = v;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        smp_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R9: reset state
        chk("R9 dec_valid", int'(dec_valid), 0);
        chk("R9 dec_sym", int'(dec_sym), 0);
        for (int k = 1; k <= TAP_N; k++) chk("R9 tap", tap(k), 0);

        // R3/R4 slicer table, training frozen
        freeze = 1'b1;
        mu_shift = '0;
        for (int i = 0; i < 12; i++) begin
            pam4_mode = VEC[i][14];
            step(int'($signed(VEC[i][13:2])), 1'b1);
            chk(VEC[i][14] ? "R3 code" : "R4 code", int'(dec_sym), int'(VEC[i][1:0]));
            chk("R1 valid", int'(dec_valid), 1);
        end
        chk("R8 tap1 frozen", tap(1), 0);

        // A: training, ISI subtraction, freeze, idle cycle
        do_reset();
        pam4_mode = 1'b0;
        freeze = 1'b0;
        step(100, 1'b1);
        chk("R6 empty history", tap(1), 0);
        step(200, 1'b1);
        chk("R6 R5 tap1 from e=72", tap(1), 4608);
        freeze = 1'b1;
        step(0, 1'b1);
        chk("R2 corrected to -72", int'(dec_sym), 0);
        chk("R8 frozen tap1", tap(1), 4608);
        freeze = 1'b0;
        step(1000, 1'b0);
        chk("R1 idle valid", int'(dec_valid), 0);
        chk("R1 idle sym held", int'(dec_sym), 0);
        chk("R1 idle tap1", tap(1), 4608);

        // B: shift amount and floor rounding
        do_reset();
        mu_shift = 4'd4;
        step(100, 1'b1);
        step(100, 1'b1);
        chk("R6 mu=4", tap(1), -112);
        mu_shift = 4'd15;
        step(100, 1'b1);
        chk("R6 mu=15 tap1", tap(1), -113);
        chk("R6 mu=15 tap2", tap(2), -1);

        // C: multi-tap indexing
        do_reset();
        mu_shift = '0;
        step(200, 1'b1);
        step(-200, 1'b1);
        chk("R6 tap1 first", tap(1), -4608);
        step(0, 1'b1);
        chk("R2 decision with tap1", int'(dec_sym), 0);
        chk("R6 R10 tap1", tap(1), -8192);
        chk("R6 R10 tap2", tap(2), 3584);
        chk("R10 tap3", tap(3), 0);

        // D: saturation in PAM4
        do_reset();
        pam4_mode = 1'b1;
        step(2047, 1'b1);
        step(2047, 1'b1);
        chk("R3 top code", int'(dec_sym), 2);
        chk("R7 positive clamp", tap(1), 131071);
        do_reset();
        chk("R9 reset clears tap1", tap(1), 0);
        step(-2048, 1'b1);
        step(2047, 1'b1);
        chk("R7 negative clamp", tap(1), -131072);
        step(2047, 1'b1);
        chk("R7 tap1 swings to max", tap(1), 131071);
        chk("R7 tap2 min", tap(2), -131072);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule